// File: doc/BRIEF.md
# Flash Line Read Sequencer

This block answers 32-bit reads aimed at a memory-mapped window over serial flash. It holds one line of 1024 bytes. A read whose address falls inside that line gets its word from the line buffer one cycle after it is accepted. Any other read causes a refill. The block selects one flash device and sends a header over a byte-wide transfer port: a command byte, three address bytes, an optional mode byte and a number of zero dummy bytes. It then clocks in 1024 data bytes to fill the buffer and returns the word that was asked for.

The window covers two flash devices of 2^24 bytes each, so it spans 2^25 bytes. When both buses are active, the window address is halved to form the flash address. Bits above bit 23 of the flash address choose the device. The serial PHY sits behind the byte transfer port, and the device sits behind the PHY.

Top module: `flash_line_reader`

## Requirements
- R1: A read hits when the buffer is valid and base ≤ address ≤ base+1020 (byte addresses). A hit gets `rsp_valid` in the cycle after acceptance, carrying buffer word (address−base)/4, and it causes no byte transfers.
- R2: On a miss, the first byte sent is configuration bits 7:0 (the command). The flash address follows as three bytes: bits 23:16, then 15:8, then 7:0.
- R3: When configuration bit 25 is 1, one mode byte equal to configuration bits 23:16 follows the address bytes. When bit 25 is 0, no mode byte is sent.
- R4: After the address and mode bytes, the block sends as many 0x00 dummy bytes as configuration bits 10:8 give (0 to 7).
- R5: After the header, the block makes exactly 1024 transfers, each sending 0x00. Received bytes are packed little-endian: the first byte of each group of four goes to bits 7:0. Bytes received during the header are discarded.
- R6: The flash address is the byte address when `bus_dual` is 0, and the byte address divided by 2 when it is 1. The device index is flash address bit 24. During a refill, only `cs_n[index]` is low. Outside a refill, all chip selects are high.
- R7: `rd_ready` is low from the cycle after a miss is accepted until the miss has been answered. No response is issued while a transfer is outstanding.
- R8: After reset, the buffer is invalid, so the first read is a miss. The outputs read `rd_ready`=1, `rsp_valid`=0, `xfer_req`=0 and `cs_n` all ones.
- R9: After a refill, the buffer base is the address of the read that missed. That read is answered with word 0 of the new line. An address one word below the base, or 1024 bytes above it, is a miss.
- R10: `cfg_word` and `bus_dual` are sampled when a miss is accepted. Changing them during the refill does not change the bytes sent.
- R11: While `xfer_req` is high and `xfer_ack` is low, `xfer_tx` and `cs_n` hold their values. `xfer_req` stays high until `xfer_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high with rd_valid |
| rd_waddr | input | ADDR_W-2 | Word address inside the window |
| bus_dual | input | 1 | 1 when both buses are active (address halved) |
| cfg_word | input | 32 | Command, mode-enable, mode byte and dummy count |
| rsp_valid | output | 1 | Read data valid (one-cycle pulse) |
| rsp_data | output | 32 | Read data word |
| cs_n | output | 2^(ADDR_W-24) | Active-low chip selects, one per device |
| xfer_req | output | 1 | Byte transfer request |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Transfer completes in a cycle where req and ack are both high |
| xfer_rx | input | 8 | Byte received, valid with xfer_ack |

## Verification
A hit response and the acceptance of the next request can happen in the same cycle, because `rd_ready` stays high while a hit answer is being driven. The bench holds `rd_valid` high across two consecutive hit addresses. It checks that the first word appears on `rsp_data` in the cycle the second request is taken, and that the second word follows one cycle later. This shows the registered buffer read and the new lookup do not disturb each other.

// File: rtl/flr_pkg.sv
package flr_pkg;

    localparam int          DEV_AW      = 24;
    localparam logic [31:0] CFG_DEFAULT = 32'h03A0_02EB;
    localparam int          MODE_EN_BIT = 25;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HEAD,
        SQ_FILL
    } sq_state_t;

    typedef struct packed {
        logic [31:0]       cfg;
        logic [DEV_AW-1:0] dev_addr;
    } refill_ctx_t;

    function automatic logic [3:0] head_len(input logic [31:0] cfg);
        return 4'd4 + {3'd0, cfg[MODE_EN_BIT]} + {1'b0, cfg[10:8]};
    endfunction

    function automatic logic [7:0] head_byte(input refill_ctx_t c, input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = c.cfg[7:0];
            4'd1:    b = c.dev_addr[23:16];
            4'd2:    b = c.dev_addr[15:8];
            4'd3:    b = c.dev_addr[7:0];
            4'd4:    b = c.cfg[MODE_EN_BIT] ? c.cfg[23:16] : 8'h00;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/flr_hit.sv
module flr_hit #(
    parameter int WA_W  = 23,
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             valid,
    input  logic [WA_W-1:0]  base,
    input  logic [WA_W-1:0]  waddr,
    output logic             hit,
    output logic [IDX_W-1:0] off
);
    logic [WA_W-1:0] diff;

    always_comb begin
        diff = waddr - base;
        hit  = valid && (waddr >= base) && (diff < WA_W'(WORDS));
        off  = diff[IDX_W-1:0];
    end
endmodule

// File: rtl/flr_line_buf.sv
module flr_line_buf #(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
        rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/flr_seq.sv
module flr_seq
    import flr_pkg::*;
#(
    parameter int LINE_BYTES = 1024,
    parameter int DEV_W      = 1,
    localparam int NUM_DEV   = 1 << DEV_W,
    localparam int BCNT_W    = $clog2(LINE_BYTES),
    localparam int WIDX_W    = BCNT_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  refill_ctx_t       ctx_in,
    input  logic [DEV_W-1:0]  dev_in,
    input  logic              xfer_ack,
    input  logic [7:0]        xfer_rx,
    output logic              xfer_req,
    output logic [7:0]        xfer_tx,
    output logic [NUM_DEV-1:0] cs_n,
    output logic              busy,
    output logic              wr_en,
    output logic [WIDX_W-1:0] wr_idx,
    output logic [31:0]       wr_data,
    output logic              done
);
    localparam logic [BCNT_W-1:0] LAST_BYTE = BCNT_W'(LINE_BYTES - 1);

    sq_state_t         state;
    refill_ctx_t       ctx;
    logic [DEV_W-1:0]  dev;
    logic [3:0]        hcnt;
    logic [BCNT_W-1:0] bcnt;
    logic [23:0]       asm_q;
    logic              fire;

    assign busy     = (state != SQ_IDLE);
    assign xfer_req = busy;
    assign xfer_tx  = (state == SQ_HEAD) ? head_byte(ctx, hcnt) : 8'h00;
    assign fire     = xfer_req && xfer_ack;
    assign wr_en    = (state == SQ_FILL) && fire && (&bcnt[1:0]);
    assign wr_idx   = bcnt[BCNT_W-1:2];
    assign wr_data  = {xfer_rx, asm_q};
    assign done     = (state == SQ_FILL) && fire && (bcnt == LAST_BYTE);

    for (genvar i = 0; i < NUM_DEV; i++) begin : g_cs
        assign cs_n[i] = !(busy && (dev == DEV_W'(i)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            ctx   <= '0;
            dev   <= '0;
            hcnt  <= '0;
            bcnt  <= '0;
            asm_q <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    ctx   <= ctx_in;
                    dev   <= dev_in;
                    hcnt  <= '0;
                    bcnt  <= '0;
                    state <= SQ_HEAD;
                end
                SQ_HEAD: if (fire) begin
                    hcnt <= hcnt + 4'd1;
                    if (hcnt == head_len(ctx.cfg) - 4'd1) state <= SQ_FILL;
                end
                SQ_FILL: if (fire) begin
                    asm_q <= {xfer_rx, asm_q[23:8]};
                    bcnt  <= bcnt + 1'b1;
                    if (bcnt == LAST_BYTE) state <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_line_reader.sv
module flash_line_reader
    import flr_pkg::*;
#(
    parameter int ADDR_W     = 25,
    parameter int LINE_BYTES = 1024
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                rd_valid,
    output logic                                rd_ready,
    input  logic [ADDR_W-3:0]                   rd_waddr,
    input  logic                                bus_dual,
    input  logic [31:0]                         cfg_word,
    output logic                                rsp_valid,
    output logic [31:0]                         rsp_data,
    output logic [(1<<(ADDR_W-DEV_AW))-1:0]     cs_n,
    output logic                                xfer_req,
    output logic [7:0]                          xfer_tx,
    input  logic                                xfer_ack,
    input  logic [7:0]                          xfer_rx
);
    localparam int WA_W    = ADDR_W - 2;
    localparam int DEV_W   = ADDR_W - DEV_AW;
    localparam int NUM_DEV = 1 << DEV_W;
    localparam int WORDS   = LINE_BYTES / 4;
    localparam int IDX_W   = $clog2(WORDS);

    logic [WA_W-1:0]   base_w;
    logic [WA_W-1:0]   pend_w;
    logic              base_ok;
    logic              look;
    logic              hit;
    logic [IDX_W-1:0]  off;
    logic              accept;
    logic              busy;
    logic              done;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [31:0]       wr_data;
    logic [ADDR_W-1:0] byte_addr;
    logic [ADDR_W-1:0] flash_addr;
    refill_ctx_t       ctx_in;

    assign rd_ready   = !busy && !look;
    assign accept     = rd_valid && rd_ready;
    assign byte_addr  = {rd_waddr, 2'b00};
    assign flash_addr = bus_dual ? {1'b0, byte_addr[ADDR_W-1:1]} : byte_addr;
    assign ctx_in.cfg      = cfg_word;
    assign ctx_in.dev_addr = flash_addr[DEV_AW-1:0];

    flr_hit #(.WA_W(WA_W), .WORDS(WORDS)) u_hit (
        .valid (base_ok),
        .base  (base_w),
        .waddr (rd_waddr),
        .hit   (hit),
        .off   (off)
    );

    flr_seq #(.LINE_BYTES(LINE_BYTES), .DEV_W(DEV_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (accept && !hit),
        .ctx_in   (ctx_in),
        .dev_in   (flash_addr[ADDR_W-1:DEV_AW]),
        .xfer_ack (xfer_ack),
        .xfer_rx  (xfer_rx),
        .xfer_req (xfer_req),
        .xfer_tx  (xfer_tx),
        .cs_n     (cs_n),
        .busy     (busy),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .done     (done)
    );

    flr_line_buf #(.WORDS(WORDS)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (look ? '0 : off),
        .rd_data (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_w    <= '0;
            pend_w    <= '0;
            base_ok   <= 1'b0;
            look      <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= (accept && hit) || look;
            look      <= done;
            if (accept && !hit) pend_w <= rd_waddr;
            if (done) begin
                base_w  <= pend_w;
                base_ok <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/flr_chk.sv
module flr_chk #(
    parameter int CS_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic            rsp_valid,
    input logic            xfer_req,
    input logic            xfer_ack,
    input logic [7:0]      xfer_tx,
    input logic [CS_W-1:0] cs_n
);
    p_cs_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> ($countones(~cs_n) == 1));

    p_cs_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !xfer_req |-> (&cs_n));

    p_ready_low_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> !rd_ready);

    p_no_rsp_busy_r7: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> !rsp_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx) && $stable(cs_n)));

    p_accept_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> (rsp_valid || xfer_req));
endmodule

bind flash_line_reader flr_chk #(.CS_W(NUM_DEV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rsp_valid (rsp_valid),
    .xfer_req  (xfer_req),
    .xfer_ack  (xfer_ack),
    .xfer_tx   (xfer_tx),
    .cs_n      (cs_n)
);

// File: tb/flash_line_reader_tb.sv
module flash_line_reader_tb;
    import flr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_valid = 1'b0;
    logic        rd_ready;
    logic [22:0] rd_waddr = '0;
    logic        bus_dual = 1'b0;
    logic [31:0] cfg_word = CFG_DEFAULT;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [1:0]  cs_n;
    logic        xfer_req;
    logic [7:0]  xfer_tx;
    logic        xfer_ack = 1'b0;
    logic [7:0]  xfer_rx = 8'h00;

    int n_chk = 0, n_err = 0;
    int mcnt = 0, mtot = 0;
    int data_tx_bad = 0, cs_bad = 0, stab_err = 0, ready_bad = 0;
    logic [7:0]  tx_log [16];
    logic        m_dev = 1'b0;
    logic [31:0] exp_cfg = CFG_DEFAULT;
    logic        held = 1'b0;
    logic [7:0]  ptx = 8'h00;
    logic [1:0]  pcs = 2'b11;
    bit          done_flag = 1'b0;

    always #5 clk = ~clk;

    flash_line_reader u_dut (
        .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_waddr(rd_waddr), .bus_dual(bus_dual), .cfg_word(cfg_word),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .cs_n(cs_n),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
    );

    function automatic int hlen(input logic [31:0] c);
        return 4 + int'(c[25]) + int'(c[10:8]);
    endfunction

    function automatic logic [7:0] pat(input logic [24:0] x);
        return x[7:0] ^ x[15:8] ^ x[23:16] ^ {x[24], 7'h00} ^ 8'h3C;
    endfunction

    function automatic logic [31:0] exp_word(input logic [22:0] w, input int k, input logic dual);
        logic [24:0] f;
        f = ({w, 2'b00} >> dual) + 25'(4 * k);
        return {pat(f + 25'd3), pat(f + 25'd2), pat(f + 25'd1), pat(f)};
    endfunction

    function automatic logic [7:0] mresp(input int idx);
        if (idx < hlen(exp_cfg)) return 8'hEE;
        return pat({m_dev, tx_log[1], tx_log[2], tx_log[3]} + 25'(idx - hlen(exp_cfg)));
    endfunction

    // flash side model
    always @(posedge clk) begin
        if (rst) begin
            xfer_ack <= 1'b0;
            mcnt = 0;
            held <= 1'b0;
        end else begin
            if (held && xfer_req && (xfer_tx !== ptx || cs_n !== pcs)) stab_err++;
            held <= xfer_req && !xfer_ack;
            ptx  <= xfer_tx;
            pcs  <= cs_n;
            if (&cs_n) mcnt = 0;
            if (xfer_req && xfer_ack) begin
                if (mcnt < 16) tx_log[mcnt] = xfer_tx;
                if (mcnt >= hlen(exp_cfg) && xfer_tx != 8'h00) data_tx_bad++;
                if ($countones(~cs_n) != 1) cs_bad++;
                m_dev = !cs_n[1];
                mcnt++;
                mtot++;
                xfer_ack <= 1'b0;
            end else begin
                xfer_ack <= xfer_req;
            end
            xfer_rx <= mresp(mcnt);
        end
    end

    always @(negedge clk) if (!rst && xfer_req && rd_ready) ready_bad++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [22:0] wa, input logic chg, input logic [31:0] cfg2,
                           output logic [31:0] d, output int lat, output int nb);
        int s0;
        s0 = mtot;
        @(negedge clk);
        rd_valid = 1'b1;
        rd_waddr = wa;
        while (!rd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
        if (chg) cfg_word = cfg2;
        lat = 1;
        while (!rsp_valid && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        d  = rsp_data;
        nb = mtot - s0;
    endtask

    task automatic check_head(input string tag, input logic [31:0] c, input logic [24:0] fa);
        int n;
        chk({tag, " R2 cmd"}, {24'd0, tx_log[0]}, {24'd0, c[7:0]});
        chk({tag, " R2 addr"}, {8'd0, tx_log[1], tx_log[2], tx_log[3]}, {8'd0, fa[23:0]});
        n = 4;
        if (c[25]) begin
            chk({tag, " R3 mode"}, {24'd0, tx_log[4]}, {24'd0, c[23:16]});
            n = 5;
        end
        for (int i = 0; i < int'(c[10:8]); i++)
            chk({tag, " R4 dummy"}, {24'd0, tx_log[n + i]}, 32'd0);
        chk({tag, " R6 device"}, {31'd0, m_dev}, {31'd0, fa[24]});
    endtask

    task automatic t_reset;
        chk("R8 reset rd_ready", {31'd0, rd_ready}, 32'd1);
        chk("R8 reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R8 reset xfer_req", {31'd0, xfer_req}, 32'd0);
        chk("R8 reset cs_n", {30'd0, cs_n}, 32'd3);
    endtask

    task automatic t_first_miss;
        logic [31:0] d; int lat, nb;
        exp_cfg = CFG_DEFAULT; cfg_word = CFG_DEFAULT; bus_dual = 1'b0;
        do_read(23'h100, 1'b0, 32'd0, d, lat, nb);
        chk("R8 first read misses", nb, 32'd1031);
        chk("R9 miss answer word0 R5", d, exp_word(23'h100, 0, 1'b0));
        check_head("default", CFG_DEFAULT, 25'h400);
        chk("R6 cs released", {30'd0, cs_n}, 32'd3);
    endtask

    task automatic t_hits;
        logic [31:0] d; int lat, nb;
        do_read(23'h100 + 23'd255, 1'b0, 32'd0, d, lat, nb);
        chk("R1 top hit data", d, exp_word(23'h100, 255, 1'b0));
        chk("R1 top hit latency", lat, 32'd1);
        chk("R1 top hit no xfer", nb, 32'd0);
        do_read(23'h100 + 23'd77, 1'b0, 32'd0, d, lat, nb);
        chk("R1 mid hit data", d, exp_word(23'h100, 77, 1'b0));
        chk("R1 mid hit no xfer", nb, 32'd0);
    endtask

    task automatic t_edges;
        logic [31:0] d; int lat, nb;
        do_read(23'h100 + 23'd256, 1'b0, 32'd0, d, lat, nb);
        chk("R9 base+1024 misses", nb, 32'd1031);
        chk("R9 new line word0", d, exp_word(23'h200, 0, 1'b0));
        do_read(23'h1FF, 1'b0, 32'd0, d, lat, nb);
        chk("R9 base-4 misses", nb, 32'd1031);
        chk("R9 base-4 data", d, exp_word(23'h1FF, 0, 1'b0));
    endtask

    task automatic t_cfg_forms;
        logic [31:0] d; int lat, nb;
        exp_cfg = 32'h0000_0003; cfg_word = exp_cfg;
        do_read(23'h2000, 1'b0, 32'd0, d, lat, nb);
        chk("R3 R4 no mode no dummy count", nb, 32'd1028);
        check_head("plain", exp_cfg, 25'h8000);
        chk("R5 plain data", d, exp_word(23'h2000, 0, 1'b0));
        exp_cfg = 32'h0255_050B; cfg_word = exp_cfg;
        do_read(23'h3000, 1'b0, 32'd0, d, lat, nb);
        chk("R3 R4 mode plus 5 dummy count", nb, 32'd1034);
        check_head("mode5", exp_cfg, 25'hC000);
        chk("R5 mode5 data", d, exp_word(23'h3000, 0, 1'b0));
    endtask

    task automatic t_devices;
        logic [31:0] d; int lat, nb;
        exp_cfg = CFG_DEFAULT; cfg_word = CFG_DEFAULT; bus_dual = 1'b0;
        do_read(23'h40_0100, 1'b0, 32'd0, d, lat, nb);
        check_head("dev1", exp_cfg, 25'h100_0400);
        chk("R6 dev1 data", d, exp_word(23'h40_0100, 0, 1'b0));
        bus_dual = 1'b1;
        do_read(23'h60_0000, 1'b0, 32'd0, d, lat, nb);
        check_head("dual", exp_cfg, 25'h0C0_0000);
        chk("R6 dual data", d, exp_word(23'h60_0000, 0, 1'b1));
        do_read(23'h60_0001, 1'b0, 32'd0, d, lat, nb);
        chk("R1 dual hit data", d, exp_word(23'h60_0000, 1, 1'b1));
        bus_dual = 1'b0;
    endtask

    task automatic t_cfg_snapshot;
        logic [31:0] d; int lat, nb;
        exp_cfg = 32'h0000_010B; cfg_word = exp_cfg;
        do_read(23'h5000, 1'b1, 32'h02FF_07AA, d, lat, nb);
        chk("R10 bytes follow sampled cfg", nb, 32'd1029);
        check_head("snap R10", 32'h0000_010B, 25'h1_4000);
        chk("R10 data", d, exp_word(23'h5000, 0, 1'b0));
        cfg_word = CFG_DEFAULT; exp_cfg = CFG_DEFAULT;
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        rd_valid = 1'b1; rd_waddr = 23'h5003;
        @(posedge clk);
        @(negedge clk);
        chk("R1 b2b first valid", {31'd0, rsp_valid}, 32'd1);
        chk("R1 b2b first data", rsp_data, exp_word(23'h5000, 3, 1'b0));
        chk("R1 b2b ready during rsp", {31'd0, rd_ready}, 32'd1);
        rd_waddr = 23'h5000 + 23'd200;
        @(posedge clk);
        @(negedge clk);
        rd_valid = 1'b0;
        chk("R1 b2b second valid", {31'd0, rsp_valid}, 32'd1);
        chk("R1 b2b second data", rsp_data, exp_word(23'h5000, 200, 1'b0));
    endtask

    task automatic t_global;
        chk("R7 ready low while transferring", ready_bad, 32'd0);
        chk("R11 held tx and cs", stab_err, 32'd0);
        chk("R6 single cs during transfer", cs_bad, 32'd0);
        chk("R5 data phase sends zero", data_tx_bad, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_first_miss();
        t_hits();
        t_edges();
        t_cfg_forms();
        t_devices();
        t_cfg_snapshot();
        t_back_to_back();
        t_global();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule